// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write side of a parallel NOR flash bus interface and turns sequences of bus writes into single-cycle command pulses. Each accepted write presents an address and a data word. The decoder checks an address/data unlock prefix before it accepts any multi-cycle command. The prefix is AA written to 555 followed by 55 written to 2AA. After the prefix, the decoder walks through the program, erase, identification and protection-register families.

A few commands are a single write with no prefix: erase suspend, erase resume and the short identification exit. The decoder tracks three mode flags: identification mode, erase-suspended, and a sticky single-pulse program mode. In single-pulse program mode every later write is reported as a direct program. When a command completes, the decoder presents the command code for one cycle together with the address and data of the final write. The array controller downstream acts on that pulse and drives the busy input while an embedded operation runs.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous reset, cmd_valid, id_mode, sp_mode and erase_susp are all 0 and the decoder is idle.
- R2: The writes AA@555, 55@2AA, A0@555 followed by any address/data produce cmd_op=1 (program) with cmd_valid high for exactly the cycle after the fourth write, and tgt_addr/tgt_data equal to that write's full address and data.
- R3: Matching uses only address bits 10..0 and data bits 7..0, so 0xAAA and 0x2AA are equivalent and upper address/data bits never change the decode.
- R4: The writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA followed by a sixth write decode as follows. 10@555 gives chip erase (cmd_op=3). 30 at any address gives sector erase (cmd_op=2). 60 at any address gives lockdown (cmd_op=6). A0@555 gives single-pulse entry (cmd_op=11). Any other sixth write produces no pulse.
- R5: From idle, a single write of B0 to any address gives suspend (cmd_op=4) and sets erase_susp. A single write of 30 gives resume (cmd_op=5), carries the full address in tgt_addr as the plane select, and clears erase_susp.
- R6: While erase_susp is 1, a completed chip or sector erase sequence emits no pulse.
- R7: A third write of 90@555 gives ID entry (cmd_op=7) and sets id_mode. A third write of F0@555, or a single F0 from idle, gives ID exit (cmd_op=8) and clears id_mode.
- R8: A third write of C0@555 opens the protection-register family. A fourth write at 080 with data bit 1 equal to 0 gives register lock (cmd_op=10). A fourth write at 080 with data bit 1 equal to 1 gives no pulse. A fourth write at any other address gives register program (cmd_op=9).
- R9: A write presented while busy is 1 is ignored: it produces no pulse and does not move the sequence position.
- R10: Once sp_mode is 1, every accepted write, including B0, 30 and AA, gives cmd_op=1 with that write's address and data. Only reset clears sp_mode.
- R11: A write that does not match the expected next cycle returns the decoder to idle without a pulse, and a following well-formed sequence decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One bus write this cycle |
| wr_addr | input | ADDR_W (20) | Write address |
| wr_data | input | DATA_W (16) | Write data |
| busy | input | 1 | Embedded operation running; writes ignored |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_op | output | 4 | Command code, valid with cmd_valid |
| tgt_addr | output | ADDR_W (20) | Address of the final write of the command |
| tgt_data | output | DATA_W (16) | Data of the final write of the command |
| id_mode | output | 1 | Identification mode active |
| sp_mode | output | 1 | Single-pulse program mode active |
| erase_susp | output | 1 | Erase suspended |

## Verification
The assertions assume that busy is a level supplied by the downstream controller and that each write strobe lasts one clock. They also assume that reset is the only way out of single-pulse mode, so sp_mode is never seen falling outside reset. The stimulus keeps within these assumptions: every write is a one-cycle strobe with an idle cycle after it, and busy changes only together with a strobe. Single-pulse entry is left out of the sixth-cycle sweep and exercised last, directly before a reset, so the sticky mode never masks the other sweeps.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE      = 4'd0,
    OP_PROG      = 4'd1,
    OP_SECT_ERS  = 4'd2,
    OP_CHIP_ERS  = 4'd3,
    OP_SUSPEND   = 4'd4,
    OP_RESUME    = 4'd5,
    OP_LOCKDOWN  = 4'd6,
    OP_ID_ENTER  = 4'd7,
    OP_ID_EXIT   = 4'd8,
    OP_PREG_PROG = 4'd9,
    OP_PREG_LOCK = 4'd10,
    OP_SP_ENTER  = 4'd11
  } cmd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PGM, ST_PREG, ST_ERS3, ST_ERS4, ST_ERS5
  } seq_st_e;

  // data code slots matched on the low byte
  localparam int C_AA = 0;
  localparam int C_55 = 1;
  localparam int C_A0 = 2;
  localparam int C_80 = 3;
  localparam int C_90 = 4;
  localparam int C_C0 = 5;
  localparam int C_F0 = 6;
  localparam int C_B0 = 7;
  localparam int C_30 = 8;
  localparam int C_10 = 9;
  localparam int C_60 = 10;
  localparam int NCODE = 11;

  function automatic logic [7:0] code_of(input int idx);
    case (idx)
      C_AA:    code_of = 8'hAA;
      C_55:    code_of = 8'h55;
      C_A0:    code_of = 8'hA0;
      C_80:    code_of = 8'h80;
      C_90:    code_of = 8'h90;
      C_C0:    code_of = 8'hC0;
      C_F0:    code_of = 8'hF0;
      C_B0:    code_of = 8'hB0;
      C_30:    code_of = 8'h30;
      C_10:    code_of = 8'h10;
      default: code_of = 8'h60;
    endcase
  endfunction

  typedef struct packed {
    logic             at_first;   // unlock address 555
    logic             at_second;  // unlock address 2AA
    logic             at_plock;   // protection lock address 080
    logic             bit1;       // data bit 1
    logic [NCODE-1:0] dhit;       // one bit per code slot
  } wr_class_t;

endpackage

// File: rtl/flash_cmd_class.sv
module flash_cmd_class
  import flash_cmd_pkg::*;
#(
  parameter int MATCH_W     = 11,
  parameter int FIRST_ADDR  = 'h555,
  parameter int SECOND_ADDR = 'h2AA,
  parameter int PLOCK_ADDR  = 'h080
) (
  input  logic [MATCH_W-1:0] addr_lo,
  input  logic [7:0]         data_lo,
  output wr_class_t          cls
);
  localparam logic [MATCH_W-1:0] A_FIRST  = MATCH_W'(FIRST_ADDR);
  localparam logic [MATCH_W-1:0] A_SECOND = MATCH_W'(SECOND_ADDR);
  localparam logic [MATCH_W-1:0] A_PLOCK  = MATCH_W'(PLOCK_ADDR);

  logic [NCODE-1:0] hit;

  for (genvar g = 0; g < NCODE; g++) begin : g_code
    assign hit[g] = (data_lo == code_of(g));
  end

  always_comb begin
    cls.at_first  = (addr_lo == A_FIRST);
    cls.at_second = (addr_lo == A_SECOND);
    cls.at_plock  = (addr_lo == A_PLOCK);
    cls.bit1      = data_lo[1];
    cls.dhit      = hit;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  logic      busy,
  input  wr_class_t cls,
  input  logic      sp_i,
  input  logic      susp_i,
  output logic      fire,
  output cmd_op_e   op
);
  seq_st_e st_q, st_d;
  logic    acc;

  assign acc = wr_en && !busy;

  always_comb begin
    st_d = st_q;
    fire = 1'b0;
    op   = OP_NONE;
    if (acc) begin
      st_d = ST_IDLE;
      if (sp_i) begin
        fire = 1'b1;
        op   = OP_PROG;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (cls.at_first && cls.dhit[C_AA]) st_d = ST_UNL1;
            else if (cls.dhit[C_B0]) begin fire = 1'b1; op = OP_SUSPEND; end
            else if (cls.dhit[C_30]) begin fire = 1'b1; op = OP_RESUME; end
            else if (cls.dhit[C_F0]) begin fire = 1'b1; op = OP_ID_EXIT; end
          end
          ST_UNL1: if (cls.at_second && cls.dhit[C_55]) st_d = ST_UNL2;
          ST_UNL2: begin
            if (cls.at_first) begin
              if (cls.dhit[C_A0])      st_d = ST_PGM;
              else if (cls.dhit[C_80]) st_d = ST_ERS3;
              else if (cls.dhit[C_C0]) st_d = ST_PREG;
              else if (cls.dhit[C_90]) begin fire = 1'b1; op = OP_ID_ENTER; end
              else if (cls.dhit[C_F0]) begin fire = 1'b1; op = OP_ID_EXIT; end
            end
          end
          ST_PGM: begin
            fire = 1'b1;
            op   = OP_PROG;
          end
          ST_PREG: begin
            if (!cls.at_plock) begin
              fire = 1'b1;
              op   = OP_PREG_PROG;
            end else if (!cls.bit1) begin
              fire = 1'b1;
              op   = OP_PREG_LOCK;
            end
          end
          ST_ERS3: if (cls.at_first && cls.dhit[C_AA]) st_d = ST_ERS4;
          ST_ERS4: if (cls.at_second && cls.dhit[C_55]) st_d = ST_ERS5;
          ST_ERS5: begin
            if (cls.dhit[C_10] && cls.at_first) begin
              if (!susp_i) begin fire = 1'b1; op = OP_CHIP_ERS; end
            end else if (cls.dhit[C_30]) begin
              if (!susp_i) begin fire = 1'b1; op = OP_SECT_ERS; end
            end else if (cls.dhit[C_60]) begin
              fire = 1'b1;
              op   = OP_LOCKDOWN;
            end else if (cls.dhit[C_A0] && cls.at_first) begin
              fire = 1'b1;
              op   = OP_SP_ENTER;
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(st_q)); // R9
  AST_SUSP_NO_ERASE: assert property (@(posedge clk) disable iff (rst)
    (fire && susp_i) |-> (op != OP_CHIP_ERS && op != OP_SECT_ERS)); // R6
  AST_SP_IDLE: assert property (@(posedge clk) disable iff (rst)
    sp_i |-> (st_q == ST_IDLE)); // R10
endmodule

// File: rtl/flash_cmd_mode.sv
module flash_cmd_mode
  import flash_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    fire,
  input  cmd_op_e op,
  output logic    id_q,
  output logic    sp_q,
  output logic    susp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      id_q   <= 1'b0;
      sp_q   <= 1'b0;
      susp_q <= 1'b0;
    end else if (fire) begin
      case (op)
        OP_ID_ENTER: id_q   <= 1'b1;
        OP_ID_EXIT:  id_q   <= 1'b0;
        OP_SP_ENTER: sp_q   <= 1'b1;
        OP_SUSPEND:  susp_q <= 1'b1;
        OP_RESUME:   susp_q <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_SP_STICKY: assert property (@(posedge clk) disable iff (rst)
    sp_q |=> sp_q); // R10
  AST_ID_ENTER_SETS: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_ID_ENTER) |=> id_q); // R7
  AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_RESUME) |=> !susp_q); // R5
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int MATCH_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              cmd_valid,
  output logic [3:0]        cmd_op,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  output logic              id_mode,
  output logic              sp_mode,
  output logic              erase_susp
);
  wr_class_t cls;
  logic      fire;
  cmd_op_e   op;

  flash_cmd_class #(.MATCH_W(MATCH_W)) u_class (
    .addr_lo (wr_addr[MATCH_W-1:0]),
    .data_lo (wr_data[7:0]),
    .cls     (cls)
  );

  flash_cmd_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .busy   (busy),
    .cls    (cls),
    .sp_i   (sp_mode),
    .susp_i (erase_susp),
    .fire   (fire),
    .op     (op)
  );

  flash_cmd_mode u_mode (
    .clk    (clk),
    .rst    (rst),
    .fire   (fire),
    .op     (op),
    .id_q   (id_mode),
    .sp_q   (sp_mode),
    .susp_q (erase_susp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      tgt_addr  <= '0;
      tgt_data  <= '0;
    end else begin
      cmd_valid <= fire;
      cmd_op    <= fire ? op : OP_NONE;
      if (fire) begin
        tgt_addr <= wr_addr;
        tgt_data <= wr_data;
      end
    end
  end

  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(wr_en && !busy)); // R9
  AST_SP_PROG_ONLY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && $past(sp_mode)) |-> (cmd_op == OP_PROG)); // R10
  AST_OP_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> (cmd_op == OP_NONE)); // R11
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [19:0] tgt_addr;
  logic [15:0] tgt_data;
  logic        id_mode, sp_mode, erase_susp;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .tgt_addr(tgt_addr),
    .tgt_data(tgt_data), .id_mode(id_mode), .sp_mode(sp_mode), .erase_susp(erase_susp)
  );

  logic [3:0]  got_op;
  logic [19:0] got_addr;
  logic [15:0] got_data;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write strobe, then capture the pulse at the following negedge
  task automatic wr(input logic [19:0] a, input logic [15:0] d, input logic bz = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; busy = bz;
    @(negedge clk);
    got_op   = cmd_valid ? cmd_op : 4'd0;
    got_addr = tgt_addr;
    got_data = tgt_data;
    wr_en = 1'b0; busy = 1'b0;
  endtask

  task automatic unlock();
    wr(20'h00555, 16'h00AA);
    wr(20'h002AA, 16'h0055);
  endtask

  task automatic erase_prefix();
    unlock();
    wr(20'h00555, 16'h0080);
    unlock();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 id_mode", id_mode, 0);
    chk("R1 sp_mode", sp_mode, 0);
    chk("R1 erase_susp", erase_susp, 0);

    // R2 program with full address/data returned
    unlock(); wr(20'h00555, 16'h00A0);
    chk("R2 no early pulse", got_op, 0);
    wr(20'hABCDE, 16'h1234);
    chk("R2 op", got_op, 1);
    chk("R2 addr", got_addr, 20'hABCDE);
    chk("R2 data", got_data, 16'h1234);
    @(negedge clk);
    chk("R2 one cycle", cmd_valid, 0);

    // R3 upper bits ignored; AAA equals 2AA
    wr(20'hFF555, 16'hFFAA); wr(20'h7FAAA, 16'h3355); wr(20'h80555, 16'hA5A0);
    wr(20'h00042, 16'h0000);
    chk("R3 upper bits ignored", got_op, 1);

    // R5/R7/R11 idle single-write sweep over every data byte
    for (int d = 0; d < 256; d++) begin
      logic [3:0] e;
      e = (d == 'hB0) ? 4'd4 : (d == 'h30) ? 4'd5 : (d == 'hF0) ? 4'd8 : 4'd0;
      wr(20'h40123, 16'(d));
      chk("R5 idle single write", got_op, e);
      if (d == 'h30) chk("R5 resume plane addr", got_addr, 20'h40123);
    end
    chk("R5 suspended after B0", erase_susp, 1);

    // R6 erase rejected while suspended; lockdown still accepted
    erase_prefix(); wr(20'h08000, 16'h0030);
    chk("R6 sector erase blocked", got_op, 0);
    erase_prefix(); wr(20'h00555, 16'h0010);
    chk("R6 chip erase blocked", got_op, 0);
    wr(20'hC0000, 16'h0030);
    chk("R5 resume", got_op, 5);
    chk("R5 resume addr", got_addr, 20'hC0000);
    chk("R5 flag cleared", erase_susp, 0);

    // R7/R8/R11 third-cycle sweep, followed by a fixed follow-on write
    for (int d = 0; d < 256; d++) begin
      logic [3:0] e3, e4;
      e3 = (d == 'h90) ? 4'd7 : (d == 'hF0) ? 4'd8 : 4'd0;
      e4 = (d == 'hA0) ? 4'd1 : (d == 'hC0) ? 4'd9 : 4'd0;
      unlock();
      wr(20'h00555, 16'(d));
      chk("R7 third cycle", got_op, e3);
      if (d == 'h90) chk("R7 id_mode set", id_mode, 1);
      if (d == 'hF0) chk("R7 id_mode cleared", id_mode, 0);
      wr(20'h00000, 16'h0000);
      chk("R11 follow-on write", got_op, e4);
    end

    // R7 single F0 exit
    unlock(); wr(20'h00555, 16'h0090);
    wr(20'h12345, 16'h00F0);
    chk("R7 single exit op", got_op, 8);
    chk("R7 single exit flag", id_mode, 0);

    // R8 protection register
    unlock(); wr(20'h00555, 16'h00C0); wr(20'h00080, 16'h00FD);
    chk("R8 lock bit1=0", got_op, 10);
    unlock(); wr(20'h00555, 16'h00C0); wr(20'h00080, 16'h0002);
    chk("R8 lock bit1=1 no pulse", got_op, 0);
    unlock(); wr(20'h00555, 16'h00C0); wr(20'h00085, 16'h5A5A);
    chk("R8 register program", got_op, 9);
    chk("R8 register program data", got_data, 16'h5A5A);

    // R9 busy writes ignored and position kept
    unlock();
    wr(20'h00000, 16'h0000, 1'b1);
    chk("R9 busy no pulse", got_op, 0);
    wr(20'h00555, 16'h00A0); wr(20'h00321, 16'h00EE);
    chk("R9 sequence kept across busy", got_op, 1);
    wr(20'h00123, 16'h00B0, 1'b1);
    chk("R9 busy suspend ignored", erase_susp, 0);

    // R11 mismatch mid-sequence then recovery
    unlock(); wr(20'h00555, 16'h0080); wr(20'h00555, 16'h0055);
    chk("R11 mismatch no pulse", got_op, 0);
    erase_prefix(); wr(20'h10000, 16'h0030);
    chk("R11 recovered sector erase", got_op, 2);

    // R4 sixth-cycle sweep (single-pulse entry kept for last)
    for (int d = 0; d < 256; d++) begin
      logic [3:0] e;
      if (d == 'hA0) continue;
      e = (d == 'h10) ? 4'd3 : (d == 'h30) ? 4'd2 : (d == 'h60) ? 4'd6 : 4'd0;
      erase_prefix();
      wr(20'h00555, 16'(d));
      chk("R4 sixth cycle", got_op, e);
    end

    // R10 single-pulse mode
    erase_prefix(); wr(20'h00555, 16'h00A0);
    chk("R4 single-pulse entry", got_op, 11);
    chk("R10 sp_mode set", sp_mode, 1);
    wr(20'h00777, 16'h00B0);
    chk("R10 B0 is program", got_op, 1);
    wr(20'h30000, 16'h0030);
    chk("R10 30 is program", got_op, 1);
    chk("R10 addr", got_addr, 20'h30000);
    wr(20'h00555, 16'h00AA);
    chk("R10 AA is program", got_op, 1);
    chk("R10 suspend not set", erase_susp, 0);
    chk("R10 still sticky", sp_mode, 1);
    do_reset();
    chk("R10 reset clears", sp_mode, 0);
    chk("R1 reset pulse clear", cmd_valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule